// File: doc/BRIEF.md
# Region-Steered Data Port Router

This block connects one 16-bit host data port to four target ports inside a DSP subsystem. Each host access is a one-cycle read or write strobe. A 3-bit region code, which is bits 14:12 of the host's port configuration register, selects the target. The four targets are data memory, the register (MMIO) space, program memory and an external bus master.

The block builds the target address in a way that depends on the region:

- **Data memory, program memory and external bus:** the 32-bit address joins the 16-bit high half from the DMA channel 0 destination-high register with the 16-bit low address.
- **MMIO:** only an 11-bit window of the low address is used.

An external-bus access is issued only when the bus master's configuration allows it. Accesses to any other region code are dropped.

Each accepted access becomes one registered single-cycle request on exactly one target port. For a read, the block captures the target's data on the following edge and presents it to the host. That value holds until the next read completes.

Top module: `pdr_router`

## Requirements
- R1: While reset is high and in the first cycle after it, every target request is low and `host_rdata` is 0.
- R2: Region codes select the target as follows: 0 is data memory, 1 is MMIO, 5 is program memory and 7 is the external bus. In the cycle after a host strobe, at most one target request is high.
- R3: Data-memory and program-memory requests carry the address `{chan_hi, low_addr}`.
- R4: An MMIO request carries `low_addr[10:0]` as its address.
- R5: A region 7 access issues an external request only if all of these hold: `bm_chan` is 0, `bm_dir` equals 1 for a write or 0 for a read, and `bm_unit` is 0, 1 or 2. The address is `{chan_hi, low_addr}`. Otherwise no request is issued, and a read returns 0.
- R6: The unit codes 0, 1 and 2 mean 8, 16 and 32 bits, and `ext_size` carries the code. An 8-bit external write sends `host_wdata & 16'h00FF`. An 8-bit read returns `ext_rdata[7:0]` zero-extended. A 16-bit or 32-bit read returns the low 16 bits of the bus master's data.
- R7: Region codes 2, 3, 4 and 6 raise no request, and a read in those regions returns 0.
- R8: `host_rdata` changes only at the second clock edge after a read strobe is sampled, and then equals the selected target's data.
- R9: A write request has `we` set to 1 and carries `host_wdata`. If `host_wr` and `host_rd` are both high, the access is a write.
- R10: A target request is high for exactly the one cycle after each sampled strobe, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Data returned to the host |
| region_sel | input | 3 | Region code (configuration bits 14:12) |
| low_addr | input | 16 | Low half of the target address |
| chan_hi | input | 16 | DMA channel 0 destination-high half |
| bm_chan | input | 2 | Bus master's configured channel |
| bm_dir | input | 1 | Bus master direction (1 write, 0 read) |
| bm_unit | input | 2 | Bus master unit size code |
| dmem_req | output | 1 | Data memory request |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 32 | Data memory address |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_rdata | input | 16 | Data memory read data |
| mmio_req | output | 1 | MMIO request |
| mmio_we | output | 1 | MMIO write enable |
| mmio_addr | output | 11 | MMIO address |
| mmio_wdata | output | 16 | MMIO write data |
| mmio_rdata | input | 16 | MMIO read data |
| pmem_req | output | 1 | Program memory request |
| pmem_we | output | 1 | Program memory write enable |
| pmem_addr | output | 32 | Program memory address |
| pmem_wdata | output | 16 | Program memory write data |
| pmem_rdata | input | 16 | Program memory read data |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External bus write enable |
| ext_addr | output | 32 | External bus address |
| ext_size | output | 2 | External unit size code |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | Low half of external read data |

## Verification
The bench uses the package defaults: 16-bit address halves, an 11-bit MMIO window and a 2-bit channel field. With a 2-bit channel field, the non-zero channels 1 to 3 exist, so the channel gate can be exercised. Unit code 3 is also reachable, so the size gate can be exercised. Every one of the eight region codes is driven, including the four unmapped ones. Low addresses with bits set above bit 10 show that the MMIO window truncates the address. Back-to-back and combined read-write strobes show that requests and read-data capture follow each other cycle by cycle.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    localparam int PDR_DW      = 16;
    localparam int PDR_AW      = 16;
    localparam int PDR_FULL_AW = 2 * PDR_AW;
    localparam int PDR_MMIO_AW = 11;
    localparam int PDR_CHAN_W  = 2;
    localparam int PDR_REG_W   = 3;
    localparam int PDR_UNIT_W  = 2;

    localparam logic [PDR_REG_W-1:0] REG_DATA = 3'd0;
    localparam logic [PDR_REG_W-1:0] REG_MMIO = 3'd1;
    localparam logic [PDR_REG_W-1:0] REG_PROG = 3'd5;
    localparam logic [PDR_REG_W-1:0] REG_EXT  = 3'd7;

    localparam logic [PDR_UNIT_W-1:0] UNIT_8  = 2'd0;
    localparam logic [PDR_UNIT_W-1:0] UNIT_16 = 2'd1;
    localparam logic [PDR_UNIT_W-1:0] UNIT_32 = 2'd2;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_DMEM = 3'd1,
        TGT_MMIO = 3'd2,
        TGT_PMEM = 3'd3,
        TGT_EXT  = 3'd4
    } tgt_e;

    typedef struct packed {
        tgt_e                    tgt;
        logic                    rd;
        logic                    we;
        logic [PDR_FULL_AW-1:0]  addr;
        logic [PDR_DW-1:0]       wdata;
        logic [PDR_UNIT_W-1:0]   size;
    } acc_t;

    function automatic logic unit_legal(input logic [PDR_UNIT_W-1:0] u);
        return (u == UNIT_8) || (u == UNIT_16) || (u == UNIT_32);
    endfunction

    function automatic logic [PDR_DW-1:0] ext_read_shape(
        input logic [PDR_UNIT_W-1:0] u, input logic [PDR_DW-1:0] d);
        return (u == UNIT_8) ? {{(PDR_DW-8){1'b0}}, d[7:0]} : d;
    endfunction
endpackage

// File: rtl/pdr_decode.sv
module pdr_decode
    import pdr_pkg::*;
(
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [PDR_DW-1:0]       host_wdata,
    input  logic [PDR_REG_W-1:0]    region_sel,
    input  logic [PDR_AW-1:0]       low_addr,
    input  logic [PDR_AW-1:0]       chan_hi,
    input  logic [PDR_CHAN_W-1:0]   bm_chan,
    input  logic                    bm_dir,
    input  logic [PDR_UNIT_W-1:0]   bm_unit,
    output acc_t                    acc
);
    logic [PDR_FULL_AW-1:0] full_addr;
    logic                   is_wr;
    logic                   ext_ok;

    assign full_addr = {chan_hi, low_addr};
    assign is_wr     = host_wr;
    assign ext_ok    = (bm_chan == '0) && (bm_dir == is_wr) && unit_legal(bm_unit);

    always_comb begin
        acc = '0;
        acc.tgt = TGT_NONE;
        if (host_wr || host_rd) begin
            acc.rd    = !is_wr;
            acc.we    = is_wr;
            acc.wdata = host_wdata;
            acc.size  = bm_unit;
            unique case (region_sel)
                REG_DATA: begin
                    acc.tgt  = TGT_DMEM;
                    acc.addr = full_addr;
                end
                REG_MMIO: begin
                    acc.tgt  = TGT_MMIO;
                    acc.addr = {{(PDR_FULL_AW-PDR_MMIO_AW){1'b0}}, low_addr[PDR_MMIO_AW-1:0]};
                end
                REG_PROG: begin
                    acc.tgt  = TGT_PMEM;
                    acc.addr = full_addr;
                end
                REG_EXT: begin
                    if (ext_ok) begin
                        acc.tgt  = TGT_EXT;
                        acc.addr = full_addr;
                        if (bm_unit == UNIT_8)
                            acc.wdata = {{(PDR_DW-8){1'b0}}, host_wdata[7:0]};
                    end
                end
                default: acc.tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pdr_issue.sv
module pdr_issue
    import pdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc_d,
    output acc_t acc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            acc_q.tgt <= TGT_NONE;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/pdr_return.sv
module pdr_return
    import pdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc_q,
    input  logic [PDR_DW-1:0] dmem_rdata,
    input  logic [PDR_DW-1:0] mmio_rdata,
    input  logic [PDR_DW-1:0] pmem_rdata,
    input  logic [PDR_DW-1:0] ext_rdata,
    output logic [PDR_DW-1:0] host_rdata
);
    logic [PDR_DW-1:0] sel_data;

    always_comb begin
        unique case (acc_q.tgt)
            TGT_DMEM: sel_data = dmem_rdata;
            TGT_MMIO: sel_data = mmio_rdata;
            TGT_PMEM: sel_data = pmem_rdata;
            TGT_EXT:  sel_data = ext_read_shape(acc_q.size, ext_rdata);
            default:  sel_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (acc_q.rd)
            host_rdata <= sel_data;
    end
endmodule

// File: rtl/pdr_router.sv
module pdr_router
    import pdr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [PDR_DW-1:0]       host_wdata,
    output logic [PDR_DW-1:0]       host_rdata,
    input  logic [PDR_REG_W-1:0]    region_sel,
    input  logic [PDR_AW-1:0]       low_addr,
    input  logic [PDR_AW-1:0]       chan_hi,
    input  logic [PDR_CHAN_W-1:0]   bm_chan,
    input  logic                    bm_dir,
    input  logic [PDR_UNIT_W-1:0]   bm_unit,
    output logic                    dmem_req,
    output logic                    dmem_we,
    output logic [PDR_FULL_AW-1:0]  dmem_addr,
    output logic [PDR_DW-1:0]       dmem_wdata,
    input  logic [PDR_DW-1:0]       dmem_rdata,
    output logic                    mmio_req,
    output logic                    mmio_we,
    output logic [PDR_MMIO_AW-1:0]  mmio_addr,
    output logic [PDR_DW-1:0]       mmio_wdata,
    input  logic [PDR_DW-1:0]       mmio_rdata,
    output logic                    pmem_req,
    output logic                    pmem_we,
    output logic [PDR_FULL_AW-1:0]  pmem_addr,
    output logic [PDR_DW-1:0]       pmem_wdata,
    input  logic [PDR_DW-1:0]       pmem_rdata,
    output logic                    ext_req,
    output logic                    ext_we,
    output logic [PDR_FULL_AW-1:0]  ext_addr,
    output logic [PDR_UNIT_W-1:0]   ext_size,
    output logic [PDR_DW-1:0]       ext_wdata,
    input  logic [PDR_DW-1:0]       ext_rdata
);
    acc_t acc_d;
    acc_t acc_q;

    pdr_decode u_decode (
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .region_sel (region_sel),
        .low_addr   (low_addr),
        .chan_hi    (chan_hi),
        .bm_chan    (bm_chan),
        .bm_dir     (bm_dir),
        .bm_unit    (bm_unit),
        .acc        (acc_d)
    );

    pdr_issue u_issue (
        .clk   (clk),
        .rst   (rst),
        .acc_d (acc_d),
        .acc_q (acc_q)
    );

    pdr_return u_return (
        .clk        (clk),
        .rst        (rst),
        .acc_q      (acc_q),
        .dmem_rdata (dmem_rdata),
        .mmio_rdata (mmio_rdata),
        .pmem_rdata (pmem_rdata),
        .ext_rdata  (ext_rdata),
        .host_rdata (host_rdata)
    );

    // Target port fan-out from the single registered access.
    assign dmem_req   = (acc_q.tgt == TGT_DMEM);
    assign mmio_req   = (acc_q.tgt == TGT_MMIO);
    assign pmem_req   = (acc_q.tgt == TGT_PMEM);
    assign ext_req    = (acc_q.tgt == TGT_EXT);

    assign dmem_we    = acc_q.we;
    assign mmio_we    = acc_q.we;
    assign pmem_we    = acc_q.we;
    assign ext_we     = acc_q.we;

    assign dmem_addr  = acc_q.addr;
    assign pmem_addr  = acc_q.addr;
    assign ext_addr   = acc_q.addr;
    assign mmio_addr  = acc_q.addr[PDR_MMIO_AW-1:0];

    assign dmem_wdata = acc_q.wdata;
    assign mmio_wdata = acc_q.wdata;
    assign pmem_wdata = acc_q.wdata;
    assign ext_wdata  = acc_q.wdata;
    assign ext_size   = acc_q.size;
endmodule

// File: rtl/pdr_router_chk.sv
module pdr_router_chk
    import pdr_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    host_wr,
    input logic                    host_rd,
    input logic [PDR_DW-1:0]       host_rdata,
    input logic [PDR_REG_W-1:0]    region_sel,
    input logic [PDR_AW-1:0]       low_addr,
    input logic [PDR_AW-1:0]       chan_hi,
    input logic [PDR_CHAN_W-1:0]   bm_chan,
    input logic                    bm_dir,
    input logic                    dmem_req,
    input logic                    dmem_we,
    input logic [PDR_FULL_AW-1:0]  dmem_addr,
    input logic                    mmio_req,
    input logic [PDR_MMIO_AW-1:0]  mmio_addr,
    input logic                    pmem_req,
    input logic                    ext_req,
    input logic                    ext_we,
    input logic [PDR_UNIT_W-1:0]   ext_size,
    input logic [PDR_DW-1:0]       ext_wdata
);
    logic unmapped;
    assign unmapped = (region_sel == 3'd2) || (region_sel == 3'd3) ||
                      (region_sel == 3'd4) || (region_sel == 3'd6);

    p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dmem_req, mmio_req, pmem_req, ext_req}));

    p_data_region_r2: assert property (@(posedge clk) disable iff (rst)
        dmem_req |-> $past(region_sel) == REG_DATA);

    p_needs_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (dmem_req || mmio_req || pmem_req || ext_req) |-> $past(host_wr || host_rd));

    p_data_addr_r3: assert property (@(posedge clk) disable iff (rst)
        dmem_req |-> dmem_addr == {$past(chan_hi), $past(low_addr)});

    p_mmio_window_r4: assert property (@(posedge clk) disable iff (rst)
        mmio_req |-> mmio_addr == $past(low_addr[PDR_MMIO_AW-1:0]));

    p_ext_gate_r5: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> ($past(bm_chan) == '0) && ($past(bm_dir) == ext_we) && (ext_size != 2'd3));

    p_byte_write_r6: assert property (@(posedge clk) disable iff (rst)
        (ext_req && ext_we && ext_size == UNIT_8) |-> ext_wdata[15:8] == 8'h00);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        dmem_req |-> dmem_we == $past(host_wr));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rst, 2) == 1'b0 && $past(rst) == 1'b0 &&
         $past(host_rd && !host_wr && unmapped, 2)) |-> host_rdata == '0);
endmodule

bind pdr_router pdr_router_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .region_sel (region_sel),
    .low_addr   (low_addr),
    .chan_hi    (chan_hi),
    .bm_chan    (bm_chan),
    .bm_dir     (bm_dir),
    .dmem_req   (dmem_req),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .mmio_req   (mmio_req),
    .mmio_addr  (mmio_addr),
    .pmem_req   (pmem_req),
    .ext_req    (ext_req),
    .ext_we     (ext_we),
    .ext_size   (ext_size),
    .ext_wdata  (ext_wdata)
);

// File: tb/pdr_router_tb.sv
module pdr_router_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [2:0]  region_sel = '0;
    logic [15:0] low_addr = '0, chan_hi = '0;
    logic [1:0]  bm_chan = '0;
    logic        bm_dir = 1'b0;
    logic [1:0]  bm_unit = '0;
    logic        dmem_req, dmem_we, mmio_req, mmio_we, pmem_req, pmem_we, ext_req, ext_we;
    logic [31:0] dmem_addr, pmem_addr, ext_addr;
    logic [10:0] mmio_addr;
    logic [15:0] dmem_wdata, mmio_wdata, pmem_wdata, ext_wdata;
    logic [15:0] dmem_rdata, mmio_rdata, pmem_rdata, ext_rdata;
    logic [1:0]  ext_size;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple target models: read data is a function of the presented address.
    assign dmem_rdata = dmem_addr[15:0] ^ 16'h1111;
    assign pmem_rdata = pmem_addr[15:0] ^ 16'h2222;
    assign mmio_rdata = {5'd0, mmio_addr} + 16'h4000;
    assign ext_rdata  = ext_addr[15:0] ^ 16'hC3C3;

    pdr_router dut_i (.*);

    // Reference model state
    bit          e_dreq, e_mreq, e_preq, e_xreq, e_we;
    logic [31:0] e_addr;
    logic [15:0] e_wdata, e_rdata, p_val;
    logic [1:0]  e_size;
    bit          p_rd;
    string       e_tag = "R1";
    string       rd_tag = "R1";
    string       p_tag;

    always @(posedge clk) begin
        if (rst) begin
            e_dreq = 0; e_mreq = 0; e_preq = 0; e_xreq = 0;
            e_rdata = '0; p_rd = 0; e_tag = "R1"; rd_tag = "R1";
        end else begin
            if (p_rd) begin
                e_rdata = p_val;
                rd_tag = p_tag;
            end
            e_dreq = 0; e_mreq = 0; e_preq = 0; e_xreq = 0;
            p_rd = 0; p_val = '0; e_tag = "R10";
            if (host_wr || host_rd) begin
                e_we = host_wr;
                e_wdata = host_wdata;
                e_addr = {chan_hi, low_addr};
                e_size = bm_unit;
                p_tag = "R8";
                case (region_sel)
                    3'd0: begin e_dreq = 1; e_tag = "R3"; p_val = e_addr[15:0] ^ 16'h1111; end
                    3'd1: begin
                        e_mreq = 1; e_tag = "R4";
                        e_addr = {21'd0, low_addr[10:0]};
                        p_val = {5'd0, low_addr[10:0]} + 16'h4000;
                    end
                    3'd5: begin e_preq = 1; e_tag = "R3"; p_val = e_addr[15:0] ^ 16'h2222; end
                    3'd7: begin
                        e_tag = "R5"; p_tag = "R5";
                        if (bm_chan == 0 && bm_dir == host_wr && bm_unit != 2'd3) begin
                            e_xreq = 1; e_tag = "R6"; p_tag = "R6";
                            if (bm_unit == 0) begin
                                e_wdata = {8'h00, host_wdata[7:0]};
                                p_val = {8'h00, e_addr[7:0] ^ 8'hC3};
                            end else begin
                                p_val = e_addr[15:0] ^ 16'hC3C3;
                            end
                        end
                    end
                    default: begin e_tag = "R7"; p_tag = "R7"; end
                endcase
                if (host_wr && host_rd) e_tag = "R9";
                p_rd = !host_wr;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(e_tag, "dmem_req", dmem_req, e_dreq);
        chk(e_tag, "mmio_req", mmio_req, e_mreq);
        chk(e_tag, "pmem_req", pmem_req, e_preq);
        chk(e_tag, "ext_req",  ext_req,  e_xreq);
        chk(rd_tag, "host_rdata", host_rdata, e_rdata);
        if (e_dreq) begin
            chk(e_tag, "dmem_addr", dmem_addr, e_addr);
            chk("R9", "dmem_we", dmem_we, e_we);
            if (e_we) chk("R9", "dmem_wdata", dmem_wdata, e_wdata);
        end
        if (e_preq) begin
            chk(e_tag, "pmem_addr", pmem_addr, e_addr);
            chk("R9", "pmem_we", pmem_we, e_we);
            if (e_we) chk("R9", "pmem_wdata", pmem_wdata, e_wdata);
        end
        if (e_mreq) begin
            chk("R4", "mmio_addr", mmio_addr, e_addr[10:0]);
            chk("R9", "mmio_we", mmio_we, e_we);
            if (e_we) chk("R9", "mmio_wdata", mmio_wdata, e_wdata);
        end
        if (e_xreq) begin
            chk("R5", "ext_addr", ext_addr, e_addr);
            chk("R6", "ext_size", ext_size, e_size);
            chk("R5", "ext_we", ext_we, e_we);
            if (e_we) chk("R6", "ext_wdata", ext_wdata, e_wdata);
        end
    end

    task automatic acc(input bit w, input bit r, input logic [2:0] reg_c,
                       input logic [15:0] lo, input logic [15:0] hi,
                       input logic [1:0] ch, input bit dir, input logic [1:0] unit,
                       input logic [15:0] wd);
        @(negedge clk);
        host_wr = w; host_rd = r; region_sel = reg_c; low_addr = lo; chan_hi = hi;
        bm_chan = ch; bm_dir = dir; bm_unit = unit; host_wdata = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        host_wr = 0; host_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with strobes asserted must not issue anything
        host_rd = 1; region_sel = 3'd0;
        repeat (3) @(negedge clk);
        rst = 0; host_rd = 0;
        repeat (2) @(negedge clk);
        // R2/R3: data and program memory, write then read
        acc(1, 0, 3'd0, 16'h1234, 16'hABCD, 2'd0, 0, 2'd0, 16'hBEEF); idle();
        acc(0, 1, 3'd0, 16'h1234, 16'hABCD, 2'd0, 0, 2'd0, 16'h0);    idle(); idle();
        acc(1, 0, 3'd5, 16'hFFFE, 16'h0001, 2'd0, 0, 2'd0, 16'h5A5A); idle();
        acc(0, 1, 3'd5, 16'h0F0F, 16'h8000, 2'd0, 0, 2'd0, 16'h0);    idle(); idle();
        // R4: MMIO window drops high low-address bits
        acc(1, 0, 3'd1, 16'hFFFF, 16'h7777, 2'd0, 0, 2'd0, 16'h0102); idle();
        acc(0, 1, 3'd1, 16'hF9AB, 16'h7777, 2'd0, 0, 2'd0, 16'h0);    idle(); idle();
        // R5: external gating (channel, direction, unit code 3)
        acc(1, 0, 3'd7, 16'h0040, 16'h0200, 2'd1, 1, 2'd1, 16'h1111); idle();
        acc(1, 0, 3'd7, 16'h0040, 16'h0200, 2'd0, 0, 2'd1, 16'h1111); idle();
        acc(0, 1, 3'd7, 16'h0040, 16'h0200, 2'd0, 1, 2'd1, 16'h0);    idle(); idle();
        acc(0, 1, 3'd7, 16'h0040, 16'h0200, 2'd3, 0, 2'd1, 16'h0);    idle(); idle();
        acc(0, 1, 3'd7, 16'h0040, 16'h0200, 2'd0, 0, 2'd3, 16'h0);    idle(); idle();
        // R6: each unit size, write and read
        for (int u = 0; u < 3; u++) begin
            acc(1, 0, 3'd7, 16'h3456 + u, 16'h0002, 2'd0, 1, u[1:0], 16'hA7C9); idle();
            acc(0, 1, 3'd7, 16'h3456 + u, 16'h0002, 2'd0, 0, u[1:0], 16'h0);    idle(); idle();
        end
        // R7: unmapped codes, reads return zero, writes are dropped
        acc(0, 1, 3'd0, 16'h0077, 16'h0, 2'd0, 0, 2'd0, 16'h0); idle(); idle();
        for (int c = 2; c < 7; c++) begin
            if (c == 5) continue;
            acc(1, 0, c[2:0], 16'h1357, 16'h2468, 2'd0, 1, 2'd1, 16'hDEAD); idle();
            acc(0, 1, c[2:0], 16'h1357, 16'h2468, 2'd0, 0, 2'd1, 16'h0);    idle(); idle();
        end
        // R9: simultaneous read and write acts as a write; rdata holds (R8)
        acc(0, 1, 3'd0, 16'h0A0A, 16'h0, 2'd0, 0, 2'd0, 16'h0); idle(); idle();
        acc(1, 1, 3'd0, 16'h0B0B, 16'h0, 2'd0, 0, 2'd0, 16'hCAFE); idle(); idle();
        // R10/R8: back-to-back strobes across regions
        acc(0, 1, 3'd0, 16'h0001, 16'h0009, 2'd0, 0, 2'd0, 16'h0);
        acc(0, 1, 3'd1, 16'h0802, 16'h0009, 2'd0, 0, 2'd0, 16'h0);
        acc(0, 1, 3'd5, 16'h0003, 16'h0009, 2'd0, 0, 2'd0, 16'h0);
        acc(0, 1, 3'd7, 16'h0004, 16'h0009, 2'd0, 0, 2'd0, 16'h0);
        acc(0, 1, 3'd3, 16'h0005, 16'h0009, 2'd0, 0, 2'd0, 16'h0);
        idle(); idle();
        // Mixed traffic (R2..R10) with wide coverage of codes
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            host_wr = ($urandom % 3) == 0;
            host_rd = ($urandom % 3) == 0;
            region_sel = 3'($urandom);
            low_addr = 16'($urandom);
            chan_hi = 16'($urandom);
            bm_chan = (($urandom % 2) == 0) ? 2'd0 : 2'($urandom);
            bm_dir = 1'($urandom);
            bm_unit = 2'($urandom);
            host_wdata = 16'($urandom);
        end
        idle(); idle(); idle();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule